// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block takes the output of a Reed-Solomon decoder that works on 12-bit symbols and applies the fixes to a flash page held in a byte-wide RAM inside the block. The RAM holds the data bytes first, then the spare bytes, at consecutive addresses. Two 12-bit symbols are packed into three bytes. For each symbol index, the block works out whether the symbol touches one byte or two, and which nibbles of those bytes it covers. It then does a read, an XOR with the error pattern, and a write back to the affected bytes.

Corrections arrive as (symbol index, 12-bit pattern) pairs on a valid/ready stream. The pair that ends a page carries a last flag. When the page ends, a one-cycle done pulse reports either how many corrections were applied or that the page cannot be corrected. While the block is idle, a simple host port can load and read back the RAM.

Top module: `rs_fix_apply`

## Requirements
- R1: After reset, in_ready is 1, done is 0, fail is 0 and fix_count is 0.
- R2: For an odd symbol index p (linear byte address b = floor(3p/2)), byte b is XORed with pattern bits 11:4. Byte b+1 is XORed with pattern bits 3:0 placed in bits 7:4.
- R3: For an even non-zero index p (same b), byte b-1 is XORed with pattern bits 11:8 placed in bits 3:0. Byte b is XORed with pattern bits 7:0.
- R4: For index 0, a pattern of 0xFF or below is XORed into byte 0 alone. A pattern above 0xFF writes nothing and marks the page failed.
- R5: The symbol that straddles the data/spare boundary puts pattern bits 11:4 into the last data byte. It puts bits 3:0 into bits 7:4 of spare byte 0, which is linear address DATA_BYTES.
- R6: An index above MAX_SYM writes nothing and marks the page failed.
- R7: A pair that arrives after MAX_FIX pairs have been applied in the same page writes nothing and marks the page failed.
- R8: Once a page is marked failed, its remaining pairs are still accepted but change no byte, and its done pulse carries fail=1.
- R9: done pulses for one cycle after the last pair of a page is handled. fix_count gives the number of pairs applied in that page, and both fail and fix_count hold until the next done. The next page starts from a count of zero with no failure.
- R10: Each byte update spends one read cycle and then one write cycle, and in_ready is 0 throughout the update.
- R11: While the block is idle, host_we writes host_wdata at host_addr, and host_rdata returns the byte at host_addr one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Correction pair valid |
| in_ready | output | 1 | Block can accept a pair |
| in_pos | input | POS_W | Symbol index |
| in_pat | input | 12 | Error pattern |
| in_last | input | 1 | Pair ends the page |
| done | output | 1 | One-cycle page completion pulse |
| fail | output | 1 | Page reported uncorrectable |
| fix_count | output | CNT_W | Pairs applied in the page |
| host_we | input | 1 | Host write strobe (idle only) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | RAM read byte, one cycle after address |

## Verification
The bench builds the block with 32 data bytes, 8 spare bytes, MAX_SYM=25, MAX_FIX=4 and a 5-bit index. This makes the whole index space, 0 to 31, small enough to sweep one page at a time. Every legal index, the boundary symbol 21, and every out-of-range index up to the port width can then be tried, and the full 40-byte RAM can be compared against an arithmetic model after each page. Multi-pair pages test the MAX_FIX limit, failure part-way through a page, and that state is cleared for the next page.

// File: rtl/rs_fix_pkg.sv
// Shared definitions for the symbol correction applier.
// Assumes 12-bit symbols packed two per three bytes.
package rs_fix_pkg;
    localparam int SYM_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_WR_A,
        ST_RD_B,
        ST_WR_B
    } fix_state_t;
endpackage

// File: rtl/rs_sym_map.sv
// Maps a symbol index and a 12-bit pattern to one or two byte addresses with
// XOR masks, using a linear byte address over data plus spare bytes.
// Assumes MAX_SYM keeps every produced address inside the RAM.
module rs_sym_map #(
    parameter int POS_W   = 11,
    parameter int ADDR_W  = 12,
    parameter int MAX_SYM = 1374
) (
    input  logic [POS_W-1:0]              pos,
    input  logic [rs_fix_pkg::SYM_W-1:0]  pat,
    output logic [ADDR_W-1:0]             addr_a,
    output logic [7:0]                    mask_a,
    output logic [ADDR_W-1:0]             addr_b,
    output logic [7:0]                    mask_b,
    output logic                          two,
    output logic                          bad
);
    localparam int W = (POS_W + 2 > ADDR_W) ? POS_W + 2 : ADDR_W;

    logic [W-1:0] pos_w;
    logic [W-1:0] trip;
    logic [W-1:0] half;

    assign pos_w = W'(pos);
    assign trip  = pos_w + (pos_w << 1);
    assign half  = trip >> 1;

    // Select byte addresses and nibble placement from index parity.
    always_comb begin
        addr_a = '0;
        addr_b = '0;
        mask_a = '0;
        mask_b = '0;
        two    = 1'b0;
        bad    = 1'b0;
        if (pos == '0) begin
            mask_a = pat[7:0];
            bad    = |pat[11:8];
        end else if (pos[0]) begin
            addr_a = ADDR_W'(half);
            addr_b = ADDR_W'(half + W'(1));
            mask_a = pat[11:4];
            mask_b = {pat[3:0], 4'h0};
            two    = 1'b1;
        end else begin
            addr_a = ADDR_W'(half - W'(1));
            addr_b = ADDR_W'(half);
            mask_a = {4'h0, pat[11:8]};
            mask_b = pat[7:0];
            two    = 1'b1;
        end
        if (int'(pos) > MAX_SYM) begin
            bad = 1'b1;
        end
    end
endmodule

// File: rtl/rs_page_ram.sv
// Single-port byte RAM with registered read data.
// Assumes one access per cycle; a write also refreshes the read register.
module rs_page_ram #(
    parameter int DEPTH  = 2112,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Store on write, register the addressed byte every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/rs_fix_apply.sv
// Top of the correction applier: accepts (index, pattern) pairs, performs
// read-XOR-write on the mapped bytes, and reports per-page results.
// Assumes the host port is used only while in_ready is high.
module rs_fix_apply #(
    parameter  int DATA_BYTES  = 2048,
    parameter  int SPARE_BYTES = 64,
    parameter  int MAX_SYM     = 1374,
    parameter  int MAX_FIX     = 4,
    parameter  int POS_W       = 11,
    localparam int DEPTH       = DATA_BYTES + SPARE_BYTES,
    localparam int ADDR_W      = $clog2(DEPTH),
    localparam int CNT_W       = $clog2(MAX_FIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [POS_W-1:0]  in_pos,
    input  logic [11:0]       in_pat,
    input  logic              in_last,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  fix_count,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    import rs_fix_pkg::*;

    fix_state_t        state_q;
    logic [ADDR_W-1:0] addr_a_q, addr_b_q;
    logic [7:0]        mask_a_q, mask_b_q;
    logic              two_q, last_q;
    logic [CNT_W-1:0]  cnt_q, res_cnt_q;
    logic              flt_q, done_q, res_fail_q;

    logic [ADDR_W-1:0] m_addr_a, m_addr_b;
    logic [7:0]        m_mask_a, m_mask_b;
    logic              m_two, m_bad;

    logic              accept, reject, side_a;
    logic              eng_rd, eng_wr;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata, ram_rdata;

    rs_sym_map #(
        .POS_W  (POS_W),
        .ADDR_W (ADDR_W),
        .MAX_SYM(MAX_SYM)
    ) u_map (
        .pos   (in_pos),
        .pat   (in_pat),
        .addr_a(m_addr_a),
        .mask_a(m_mask_a),
        .addr_b(m_addr_b),
        .mask_b(m_mask_b),
        .two   (m_two),
        .bad   (m_bad)
    );

    rs_page_ram #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    assign in_ready   = (state_q == ST_IDLE);
    assign accept     = in_valid && in_ready;
    assign reject     = m_bad || flt_q || (cnt_q == CNT_W'(MAX_FIX));
    assign side_a     = (state_q == ST_RD_A) || (state_q == ST_WR_A);
    assign eng_rd     = (state_q == ST_RD_A) || (state_q == ST_RD_B);
    assign eng_wr     = (state_q == ST_WR_A) || (state_q == ST_WR_B);

    // Give the RAM to the host when idle, to the engine otherwise.
    always_comb begin
        if (in_ready) begin
            ram_we    = host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end else begin
            ram_we    = eng_wr;
            ram_addr  = side_a ? addr_a_q : addr_b_q;
            ram_wdata = ram_rdata ^ (side_a ? mask_a_q : mask_b_q);
        end
    end

    assign host_rdata = ram_rdata;
    assign done       = done_q;
    assign fail       = res_fail_q;
    assign fix_count  = res_cnt_q;

    // Sequence each pair through read/write steps and publish page results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_a_q   <= '0;
            addr_b_q   <= '0;
            mask_a_q   <= '0;
            mask_b_q   <= '0;
            two_q      <= 1'b0;
            last_q     <= 1'b0;
            cnt_q      <= '0;
            flt_q      <= 1'b0;
            done_q     <= 1'b0;
            res_cnt_q  <= '0;
            res_fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (reject) begin
                            if (in_last) begin
                                done_q     <= 1'b1;
                                res_cnt_q  <= cnt_q;
                                res_fail_q <= 1'b1;
                                cnt_q      <= '0;
                                flt_q      <= 1'b0;
                            end else begin
                                flt_q <= 1'b1;
                            end
                        end else begin
                            addr_a_q <= m_addr_a;
                            addr_b_q <= m_addr_b;
                            mask_a_q <= m_mask_a;
                            mask_b_q <= m_mask_b;
                            two_q    <= m_two;
                            last_q   <= in_last;
                            state_q  <= ST_RD_A;
                        end
                    end
                end
                ST_RD_A: state_q <= ST_WR_A;
                ST_RD_B: state_q <= ST_WR_B;
                ST_WR_A, ST_WR_B: begin
                    if (state_q == ST_WR_A && two_q) begin
                        state_q <= ST_RD_B;
                    end else begin
                        state_q <= ST_IDLE;
                        if (last_q) begin
                            done_q     <= 1'b1;
                            res_cnt_q  <= CNT_W'(cnt_q + 1'b1);
                            res_fail_q <= flt_q;
                            cnt_q      <= '0;
                            flt_q      <= 1'b0;
                        end else begin
                            cnt_q <= CNT_W'(cnt_q + 1'b1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rs_fix_apply_chk.sv
// Protocol and timing checks for rs_fix_apply, attached through bind.
// Assumes signals are sampled on the rising clock edge.
module rs_fix_apply_chk #(
    parameter int MAX_SYM = 1374,
    parameter int MAX_FIX = 4,
    parameter int POS_W   = 11,
    parameter int CNT_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [POS_W-1:0] in_pos,
    input logic             done,
    input logic [CNT_W-1:0] fix_count,
    input logic             eng_rd,
    input logic             eng_wr
);
    // R10: every engine write follows an engine read of the same byte.
    assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wr |-> $past(eng_rd));

    // R10: no new pair is taken while a byte update runs.
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rd || eng_wr) |-> !in_ready);

    // R6: an out-of-range index starts no RAM access.
    assert_range_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (int'(in_pos) > MAX_SYM)) |=> (!eng_rd && in_ready));

    // R9: reported count never exceeds the per-page limit.
    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(fix_count) <= MAX_FIX));

    // R9: a page completes only with the engine back in idle.
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);
endmodule

bind rs_fix_apply rs_fix_apply_chk #(
    .MAX_SYM(MAX_SYM),
    .MAX_FIX(MAX_FIX),
    .POS_W  (POS_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_pos   (in_pos),
    .done     (done),
    .fix_count(fix_count),
    .eng_rd   (eng_rd),
    .eng_wr   (eng_wr)
);

// File: tb/sim_rs_fix_apply.sv
`timescale 1ns/1ps
module sim_rs_fix_apply;
    localparam int DATA  = 32;
    localparam int SPARE = 8;
    localparam int MSYM  = 25;
    localparam int MFIX  = 4;
    localparam int PW    = 5;
    localparam int DEP   = DATA + SPARE;
    localparam int AW    = $clog2(DEP);
    localparam int CW    = $clog2(MFIX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_pos = '0;
    logic [11:0]   in_pat = '0;
    logic          in_last = 1'b0;
    logic          done;
    logic          fail;
    logic [CW-1:0] fix_count;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;

    int total = 0;
    int bad = 0;
    logic [7:0] model [DEP];
    bit   got_done;
    int   got_cnt;
    int   got_fail;
    bit   ready_after;

    always #2.5 clk = ~clk;

    rs_fix_apply #(
        .DATA_BYTES (DATA),
        .SPARE_BYTES(SPARE),
        .MAX_SYM    (MSYM),
        .MAX_FIX    (MFIX),
        .POS_W      (PW)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_pos(in_pos),
        .in_pat(in_pat), .in_last(in_last),
        .done(done), .fail(fail), .fix_count(fix_count),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [7:0] d);
        host_addr = AW'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    // Arithmetic model of an accepted correction on the linear byte space.
    task automatic model_apply(input int p, input logic [11:0] pat);
        int b;
        b = (3 * p) / 2;
        if (p == 0) model[0] ^= pat[7:0];
        else if (p % 2 == 1) begin
            model[b]     ^= pat[11:4];
            model[b + 1] ^= {pat[3:0], 4'h0};
        end else begin
            model[b - 1] ^= {4'h0, pat[11:8]};
            model[b]     ^= pat[7:0];
        end
    endtask

    task automatic send_pair(input int p, input logic [11:0] pat, input bit last);
        while (!in_ready) @(negedge clk);
        got_done = 1'b0;
        in_valid = 1'b1; in_pos = PW'(p); in_pat = pat; in_last = last;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        ready_after = in_ready;
        for (int k = 0; k < 20; k++) begin
            if (done) begin
                got_done = 1'b1; got_cnt = int'(fix_count); got_fail = int'(fail);
                break;
            end
            if (!last && in_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic compare_ram(input string tag);
        logic [7:0] d;
        for (int a = 0; a < DEP; a++) begin
            host_read(a, d);
            chk(d == model[a], tag, int'(d), int'(model[a]));
        end
    endtask

    initial begin
        #(5ns * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] pat;
        bit exp_fail;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(fail == 1'b0, "R1 fail", int'(fail), 0);
        chk(fix_count == '0, "R1 count", int'(fix_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: preload and read back through host port
        for (int a = 0; a < DEP; a++) begin
            model[a] = 8'((a * 29 + 7) & 8'hFF);
            host_write(a, model[a]);
        end
        compare_ram("R11 host preload");

        // Sweep every index as a single-pair page (R2..R6, R10)
        for (int p = 0; p < (1 << PW); p++) begin
            pat = 12'((p * 389 + 12'h6B1) & 12'hFFF);
            if (p == 0) pat = 12'h0A5;
            exp_fail = (p > MSYM);
            send_pair(p, pat, 1'b1);
            chk(got_done, "R9 done seen", int'(got_done), 1);
            if (exp_fail) begin
                chk(got_fail == 1, "R6 fail out of range", got_fail, 1);
                chk(got_cnt == 0, "R6 count", got_cnt, 0);
                chk(ready_after == 1'b1, "R6 ready kept", int'(ready_after), 1);
                compare_ram("R6 no write");
            end else begin
                model_apply(p, pat);
                chk(got_fail == 0, "R9 fail", got_fail, 0);
                chk(got_cnt == 1, "R9 count", got_cnt, 1);
                chk(ready_after == 1'b0, "R10 busy", int'(ready_after), 0);
                if (p == 0) compare_ram("R4 symbol zero");
                else if (p == 21) compare_ram("R5 boundary");
                else if (p % 2 == 1) compare_ram("R2 odd");
                else compare_ram("R3 even");
            end
        end

        // R4: wide pattern at index 0
        send_pair(0, 12'h1A5, 1'b1);
        chk(got_fail == 1, "R4 wide pattern fail", got_fail, 1);
        chk(got_cnt == 0, "R4 wide pattern count", got_cnt, 0);
        compare_ram("R4 no write");

        // R9: full page of MAX_FIX pairs
        send_pair(3, 12'h123, 1'b0); model_apply(3, 12'h123);
        send_pair(8, 12'hABC, 1'b0); model_apply(8, 12'hABC);
        send_pair(21, 12'hF0F, 1'b0); model_apply(21, 12'hF0F);
        send_pair(25, 12'h5A5, 1'b1); model_apply(25, 12'h5A5);
        chk(got_fail == 0, "R9 four fail", got_fail, 0);
        chk(got_cnt == 4, "R9 four count", got_cnt, 4);
        compare_ram("R9 four pairs");

        // R7: fifth pair over the limit
        send_pair(1, 12'h111, 1'b0); model_apply(1, 12'h111);
        send_pair(2, 12'h222, 1'b0); model_apply(2, 12'h222);
        send_pair(4, 12'h333, 1'b0); model_apply(4, 12'h333);
        send_pair(6, 12'h444, 1'b0); model_apply(6, 12'h444);
        send_pair(7, 12'h555, 1'b1);
        chk(got_fail == 1, "R7 over limit fail", got_fail, 1);
        chk(got_cnt == 4, "R7 over limit count", got_cnt, 4);
        compare_ram("R7 fifth not written");

        // R8: failure mid-page, later pairs consumed without writes
        send_pair(5, 12'h777, 1'b0); model_apply(5, 12'h777);
        send_pair(30, 12'h888, 1'b0);
        send_pair(9, 12'h999, 1'b1);
        chk(got_fail == 1, "R8 sticky fail", got_fail, 1);
        chk(got_cnt == 1, "R8 count", got_cnt, 1);
        compare_ram("R8 no write after fail");

        // R9: state cleared for the next page
        send_pair(10, 12'h3C3, 1'b1); model_apply(10, 12'h3C3);
        chk(got_fail == 0, "R9 cleared fail", got_fail, 0);
        chk(got_cnt == 1, "R9 cleared count", got_cnt, 1);
        repeat (2) @(negedge clk);
        chk(fix_count == CW'(1), "R9 count held", int'(fix_count), 1);
        compare_ram("R9 after clear");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule